// File: doc/BRIEF.md
# Bounded Burst Pulse Generator

This block emits a fixed-length train of slow pulses after it leaves reset and then parks its output low for good. Everything lives in one system clock domain. A free-running prescaler counts up to a power of two and then wraps, and that wrap produces a one-cycle strobe. A second counter advances only on that strobe. It stops when it reaches a terminal count. At that point the pulse output is forced low and a sticky done flag rises.

The prescaler output is never used as a clock. It is only ever used as a clock enable inside the main domain. A parameter selects the output variant. In one variant the output shows a registered copy of the strobe, which gives narrow pulses. In the other a toggle flop flips on each strobe, which gives a 50/50 square wave at half the strobe rate. With the default settings the block runs on a 50 MHz system clock, has a 7-bit prescaler and stops after 40 strobes.

Top module: `burst_pulse_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the prescaler, the strobe count, the output flop and the done flag at the next rising edge of `clk`. While reset is held, `pulse_o` and `done_o` read 0.
- R2: The prescaler counts from 0 upward. Once its top bit (bit PRESC_W-1, which is 64 by default) is set, it returns to 0 on the next edge. This yields one strobe every 2^(PRESC_W-1)+1 cycles, which is 65 by default. The first strobe is taken at the 65th rising edge after reset is released.
- R3: In strobe mode (`OUT_MODE` = OUT_STROBE), `pulse_o` is high for exactly one cycle after each taken strobe edge. Numbering the first edge with `rst` low as edge 1, these are edges 65·n.
- R4: Exactly PULSE_LIMIT (default 40) strobes are counted. After that `pulse_o` stays low however long the block keeps running, and the strobe count never passes PULSE_LIMIT.
- R5: `done_o` rises one edge after the count reaches PULSE_LIMIT, which is after edge 65·40+1 by default. It then stays high until the next reset.
- R6: In toggle mode (`OUT_MODE` = OUT_TOGGLE), `pulse_o` after edge e equals the parity of min(floor(e/65), PULSE_LIMIT). It is forced to 0 once the count is complete.
- R7: Asserting reset in the middle of a burst restarts the whole sequence. Timing is then measured again from the new reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flop updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pulse_o | output | 1 | Registered pulse or toggle output |
| done_o | output | 1 | Sticky flag showing the burst has completed |

## Verification
The assertions assume three things about `rst`. It is synchronous to `clk`. It is held high across at least one rising edge before the first edge that counts. Its changes are never sampled ambiguously at an edge. The bench honours this by changing `rst` only 1 ns after a clock edge and holding it for three edges, both at start-up and for the mid-burst restart. After each release, the expected output on every edge is worked out arithmetically from the edge number, for both output variants, through the end of the burst and well beyond it.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic {
      OUT_STROBE = 1'b0,
      OUT_TOGGLE = 1'b1
   } out_mode_e;
endpackage

// File: rtl/bpg_prescaler.sv
module bpg_prescaler #(
   parameter int PRESC_W = 7
) (
   input  logic clk,
   input  logic rst,
   output logic strobe_o
);
   localparam int TOP_BIT = PRESC_W - 1;
   localparam logic [PRESC_W-1:0] WRAP_VAL = PRESC_W'(1) << TOP_BIT;

   logic [PRESC_W-1:0] presc_q;

   generate
      if (PRESC_W < 2) begin : g_bad_width
         $error("PRESC_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                 presc_q <= '0;
      else if (presc_q[TOP_BIT]) presc_q <= '0;
      else                     presc_q <= presc_q + 1'b1;
   end

   assign strobe_o = presc_q[TOP_BIT];

   assert_presc_range_R2: assert property (@(posedge clk) disable iff (rst)
      presc_q <= WRAP_VAL);
   assert_strobe_wraps_R2: assert property (@(posedge clk) disable iff (rst)
      strobe_o |=> (presc_q == '0));
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (presc_q == '0));
endmodule

// File: rtl/bpg_pulse_counter.sv
module bpg_pulse_counter #(
   parameter int PULSE_LIMIT = 40,
   parameter int CNT_W       = $clog2(PULSE_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe_i,
   output logic             active_o,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(PULSE_LIMIT);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   generate
      if (PULSE_LIMIT < 1) begin : g_bad_limit
         $error("PULSE_LIMIT must be positive");
      end
   endgenerate

   assign active_o = (cnt_q < LIMIT_V);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         if (strobe_i && active_o) cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LIMIT_V)     done_q <= 1'b1;
      end
   end

   assign count_o = cnt_q;
   assign done_o  = done_q;

   assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LIMIT_V);
   assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !strobe_i |=> $stable(cnt_q));
   assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      done_q |=> done_q);
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/bpg_out_stage.sv
module bpg_out_stage
   import burst_pkg::*;
#(
   parameter out_mode_e OUT_MODE = OUT_STROBE
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   input  logic active_i,
   output logic out_o
);
   logic out_q;

   generate
      if (OUT_MODE == OUT_TOGGLE) begin : g_toggle
         always_ff @(posedge clk) begin
            if (rst)           out_q <= 1'b0;
            else if (!active_i) out_q <= 1'b0;
            else if (strobe_i) out_q <= ~out_q;
         end
         assert_toggle_only_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
            (!strobe_i && active_i) |=> $stable(out_q));
      end else begin : g_strobe
         always_ff @(posedge clk) begin
            if (rst) out_q <= 1'b0;
            else     out_q <= strobe_i && active_i;
         end
         assert_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
            out_q |=> !out_q);
      end
   endgenerate

   assign out_o = out_q;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> !out_q);
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen
   import burst_pkg::*;
#(
   parameter int        PRESC_W     = 7,
   parameter int        PULSE_LIMIT = 40,
   parameter out_mode_e OUT_MODE    = OUT_STROBE
) (
   input  logic clk,
   input  logic rst,
   output logic pulse_o,
   output logic done_o
);
   localparam int CNT_W = $clog2(PULSE_LIMIT + 1);

   logic             strobe;
   logic             active;
   logic [CNT_W-1:0] count;

   bpg_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk      (clk),
      .rst      (rst),
      .strobe_o (strobe)
   );

   bpg_pulse_counter #(.PULSE_LIMIT(PULSE_LIMIT), .CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (strobe),
      .active_o (active),
      .count_o  (count),
      .done_o   (done_o)
   );

   bpg_out_stage #(.OUT_MODE(OUT_MODE)) u_out (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (strobe),
      .active_i (active),
      .out_o    (pulse_o)
   );

   assert_quiet_when_done_R4: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !pulse_o);
   assert_done_at_limit_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> (count == CNT_W'(PULSE_LIMIT)));
endmodule

// File: tb/burst_pulse_gen_tb.sv
module burst_pulse_gen_tb;
   import burst_pkg::*;

   localparam int PRESC_W = 7;
   localparam int LIMIT   = 40;
   localparam int PER     = (1 << (PRESC_W - 1)) + 1;
   localparam int RUN     = PER * LIMIT + 600;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pulse_s, done_s, pulse_t, done_t;
   int   checks = 0;
   int   errors = 0;

   always #2 clk = ~clk;

   burst_pulse_gen #(.PRESC_W(PRESC_W), .PULSE_LIMIT(LIMIT), .OUT_MODE(OUT_STROBE)) u_dut (
      .clk(clk), .rst(rst), .pulse_o(pulse_s), .done_o(done_s));

   burst_pulse_gen #(.PRESC_W(PRESC_W), .PULSE_LIMIT(LIMIT), .OUT_MODE(OUT_TOGGLE)) u_dut_tog (
      .clk(clk), .rst(rst), .pulse_o(pulse_t), .done_o(done_t));

   task automatic check(input string req, input int act, input int exp, input int edge_n);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s edge %0d: actual %0d expected %0d", req, edge_n, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1", pulse_s, 0, 0);
      check("R1", done_s,  0, 0);
      check("R1", pulse_t, 0, 0);
      check("R1", done_t,  0, 0);
      rst = 1'b0;
   endtask

   // Expected values after edge e (edge 1 = first edge with rst low)
   function automatic int exp_pulse(input int e);
      return (e % PER == 0 && e / PER >= 1 && e / PER <= LIMIT) ? 1 : 0;
   endfunction
   function automatic int exp_toggle(input int e);
      int f = e / PER;
      if (f > LIMIT) f = LIMIT;
      if (e > PER * LIMIT) return 0;
      return f % 2;
   endfunction
   function automatic int exp_done(input int e);
      return (e >= PER * LIMIT + 1) ? 1 : 0;
   endfunction

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int pulses;
      do_reset();
      // R7: partial burst, then restart mid-run
      for (int e = 1; e <= PER * 7 + 20; e++) begin
         @(posedge clk); #1;
         check("R3", pulse_s, exp_pulse(e), e);
      end
      do_reset();
      pulses = 0;
      for (int e = 1; e <= RUN; e++) begin
         @(posedge clk); #1;
         if (e <= PER * 3) check("R7", pulse_s, exp_pulse(e), e);
         if (e == PER - 1) check("R2", pulse_s, 0, e);
         if (e == PER)     check("R2", pulse_s, 1, e);
         check(e > PER * LIMIT ? "R4" : "R3", pulse_s, exp_pulse(e), e);
         check("R6", pulse_t, exp_toggle(e), e);
         check("R5", done_s, exp_done(e), e);
         check("R5", done_t, exp_done(e), e);
         pulses += pulse_s;
      end
      check("R4", pulses, LIMIT, RUN);
      do_reset();
      check("R1", done_s, 0, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule